// File: doc/BRIEF.md
# Segment-Load Protection Checker

This block judges a request to load a segment register. It receives the target register, the 16-bit selector, the current privilege level, a 64-bit-mode flag and the attribute bits of the descriptor that an upstream fetch unit has already read. It answers one clock later with one of two results. The first is a one-cycle commit strobe together with a usable flag for the new descriptor. The second is a one-cycle fault strobe carrying an exception kind and a 16-bit error code.

Stack-segment loads are judged by stricter rules than loads of the four data segment registers. Null selectors take separate paths for the two groups. A request that names the code segment register is always refused. When several problems are present at once, the fault reported is the one with the highest priority.

After a successful stack-segment load, the block raises an interrupt-inhibit shadow. The shadow lasts until the next instruction retires, or until a fault is delivered, whichever happens first.

Top module: `segload_checker`

## Requirements
- R1: A request whose target code is 1 (code segment) or 6 or 7 (undefined) faults with kind 1 (invalid opcode) and error code 0, whatever the other inputs are. Target codes: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS.
- R2: A selector is null when its bits 15:2 are all zero. A null selector for targets 0, 3, 4 or 5 commits with descUsable low.
- R3: A null selector for target 2 faults with kind 2 (general protection) and error code 0. The exception is 64-bit mode with cpl below 3 and the selector's bits 1:0 equal to cpl: that case commits with descUsable low.
- R4: A non-null target-2 load faults with kind 2 and error code `selector & 0xFFFC` in any of these cases: descInLimit is low; the selector's bits 1:0 differ from cpl; descDpl differs from cpl; the segment is code; the segment is not writable.
- R5: A non-null target-2 load that passes R4 but has descPresent low faults with kind 3 (stack fault) and error code `selector & 0xFFFC`.
- R6: A non-null load to target 0, 3, 4 or 5 faults with kind 2 and error code `selector & 0xFFFC` in any of these cases: descInLimit is low; the segment is code without the readable bit; the segment is data or non-conforming code and either the selector's bits 1:0 or cpl exceed descDpl.
- R7: A non-null load to target 0, 3, 4 or 5 that passes R6 but has descPresent low faults with kind 4 (not present) and error code `selector & 0xFFFC`.
- R8: The verdict for a request on loadValid appears on the next cycle. A success gives commit for one cycle, with descUsable high when the selector is non-null. A failure gives fault for one cycle. With no request, commit, fault, faultKind, errCode and descUsable are all zero, which is also the reset state.
- R9: A committed target-2 load sets intInhibit on the commit cycle. The inhibit clears after a cycle with retire high and no new successful target-2 load, or after any fault.
- R10: A second successful target-2 load while intInhibit is already high does not lengthen the shadow: the next retire still clears it.
- R11: When several checks fail at once, the fault reported follows this priority: invalid opcode, then null-selector general protection, then selector general protection, then the stack or not-present fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | Load request this cycle |
| tgtSel | input | 3 | Target segment register code |
| selector | input | 16 | Selector to load |
| cpl | input | 2 | Current privilege level |
| longMode | input | 1 | 64-bit mode flag |
| descInLimit | input | 1 | Selector index lies within the descriptor table |
| descPresent | input | 1 | Descriptor present bit |
| descDpl | input | 2 | Descriptor privilege level |
| descIsCode | input | 1 | Descriptor is a code segment (0 means data) |
| descWritable | input | 1 | Data segment writable bit |
| descReadable | input | 1 | Code segment readable bit |
| descConforming | input | 1 | Code segment conforming bit |
| retire | input | 1 | An instruction retires this cycle |
| commit | output | 1 | One-cycle success strobe |
| fault | output | 1 | One-cycle failure strobe |
| faultKind | output | 3 | 0 none, 1 invalid opcode, 2 general protection, 3 stack, 4 not present |
| errCode | output | 16 | Error code carried by the fault |
| descUsable | output | 1 | Committed descriptor is usable (low for null) |
| intInhibit | output | 1 | Interrupt-inhibit shadow |

## Verification
The bench builds the checker with its default 16-bit selector and 2-bit privilege fields. It sweeps every combination of the eight target codes, four privilege levels, four requested privileges, null and non-null selectors, four descriptor privilege levels, both mode settings and all 64 settings of the six attribute bits. Because the whole space is covered, every pairing of faults is reached, and so is every branch of the priority order. Directed sequences then cover the shadow: its set, hold, retire and fault clearing, and a repeated stack load while the shadow is already active.

// File: rtl/segchk_pkg.sv
package segchk_pkg;

  localparam int PRIV_W = 2;
  localparam int TGT_W  = 3;
  localparam int KIND_W = 3;

  typedef enum logic [TGT_W-1:0] {
    TGT_ES = 3'd0,
    TGT_CS = 3'd1,
    TGT_SS = 3'd2,
    TGT_DS = 3'd3,
    TGT_FS = 3'd4,
    TGT_GS = 3'd5
  } segTgt_e;

  typedef enum logic [KIND_W-1:0] {
    EXC_NONE  = 3'd0,
    EXC_UD    = 3'd1,
    EXC_GP    = 3'd2,
    EXC_STACK = 3'd3,
    EXC_NP    = 3'd4
  } excKind_e;

  // Condition flags produced by the datapath classifier.
  typedef struct packed {
    logic isNull;    // selector index bits all zero
    logic ssNullOk;  // null stack load allowed (64-bit, low cpl, rpl==cpl)
    logic ssSelGp;   // selector/descriptor fails stack rules
    logic dsSelGp;   // selector/descriptor fails data-register rules
    logic absent;    // descriptor not present
  } chkFlags_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capFault;  // capture an error code this cycle
    logic errZero;   // error code is zero instead of the selector
    logic capCommit; // capture usable flag this cycle
    logic usable;    // descriptor usable on commit
  } ctrlStrobe_t;

endpackage

// File: rtl/segchk_datapath.sv
module segchk_datapath
  import segchk_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] selector,
  input  logic [PRIV_W-1:0] cpl,
  input  logic             longMode,
  input  logic             descInLimit,
  input  logic             descPresent,
  input  logic [PRIV_W-1:0] descDpl,
  input  logic             descIsCode,
  input  logic             descWritable,
  input  logic             descReadable,
  input  logic             descConforming,
  input  ctrlStrobe_t      strobe,
  output chkFlags_t        flags,
  output logic [SEL_W-1:0] errCode,
  output logic             descUsable
);

  localparam int IDX_W = SEL_W - PRIV_W;
  localparam logic [PRIV_W-1:0] PRIV_MAX = {PRIV_W{1'b1}};

  logic [PRIV_W-1:0] rpl;
  logic [IDX_W-1:0]  selIdx;
  logic              typeOkData;
  logic              privChecked;
  logic              privBad;
  logic              ssTypeBad;
  logic [SEL_W-1:0]  selErr;

  assign rpl    = selector[PRIV_W-1:0];
  assign selIdx = selector[SEL_W-1:PRIV_W];
  assign selErr = {selIdx, {PRIV_W{1'b0}}};

  // Data-register rules: data, or readable code.
  assign typeOkData  = !descIsCode || descReadable;
  // Privilege compare applies to data and non-conforming code.
  assign privChecked = !descIsCode || !descConforming;
  assign privBad     = privChecked && ((rpl > descDpl) || (cpl > descDpl));
  // Stack rules: writable data only.
  assign ssTypeBad   = descIsCode || !descWritable;

  always_comb begin
    flags.isNull   = (selIdx == '0);
    flags.ssNullOk = longMode && (cpl != PRIV_MAX) && (rpl == cpl);
    flags.ssSelGp  = !descInLimit || (rpl != cpl) || (descDpl != cpl) || ssTypeBad;
    flags.dsSelGp  = !descInLimit || !typeOkData || privBad;
    flags.absent   = !descPresent;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errCode    <= '0;
      descUsable <= 1'b0;
    end else begin
      errCode    <= strobe.capFault ? (strobe.errZero ? '0 : selErr) : '0;
      descUsable <= strobe.capCommit && strobe.usable;
    end
  end

  // R8: error code is idle zero after any cycle without a fault capture.
  a_r8_err_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capFault |=> (errCode == '0));

  // R4: a captured selector-carrying error code always has its low bits clear.
  a_r4_err_low_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capFault |=> (errCode[PRIV_W-1:0] == '0));

endmodule

// File: rtl/segchk_ctrl.sv
module segchk_ctrl
  import segchk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadValid,
  input  logic [TGT_W-1:0]  tgtSel,
  input  logic              retire,
  input  chkFlags_t         flags,
  output ctrlStrobe_t       strobe,
  output logic              commit,
  output logic              fault,
  output logic [KIND_W-1:0] faultKind,
  output logic              intInhibit
);

  localparam int TGT_N = 1 << TGT_W;

  logic [TGT_N-1:0] tgtHot;
  logic             isInvalid;
  logic             isSs;
  logic             isData;
  excKind_e         verdict;
  logic             usableNext;
  logic             errZeroNext;
  logic             pass;
  logic             ssCommitNow;
  logic             faultNow;

  for (genvar i = 0; i < TGT_N; i++) begin : g_tgtDec
    assign tgtHot[i] = (tgtSel == TGT_W'(i));
  end

  assign isSs   = tgtHot[TGT_SS];
  assign isData = tgtHot[TGT_ES] | tgtHot[TGT_DS] | tgtHot[TGT_FS] | tgtHot[TGT_GS];
  // Code segment target and undefined codes are refused.
  assign isInvalid = !(isSs || isData);

  // Priority: invalid opcode, null GP, selector GP, presence.
  always_comb begin
    verdict     = EXC_NONE;
    usableNext  = 1'b1;
    errZeroNext = 1'b0;
    if (isInvalid) begin
      verdict     = EXC_UD;
      errZeroNext = 1'b1;
    end else if (isSs) begin
      if (flags.isNull) begin
        if (flags.ssNullOk) begin
          usableNext = 1'b0;
        end else begin
          verdict     = EXC_GP;
          errZeroNext = 1'b1;
        end
      end else if (flags.ssSelGp) begin
        verdict = EXC_GP;
      end else if (flags.absent) begin
        verdict = EXC_STACK;
      end
    end else begin
      if (flags.isNull) begin
        usableNext = 1'b0;
      end else if (flags.dsSelGp) begin
        verdict = EXC_GP;
      end else if (flags.absent) begin
        verdict = EXC_NP;
      end
    end
  end

  assign pass        = (verdict == EXC_NONE);
  assign ssCommitNow = loadValid && pass && isSs;
  assign faultNow    = loadValid && !pass;

  always_comb begin
    strobe.capFault  = faultNow;
    strobe.errZero   = errZeroNext;
    strobe.capCommit = loadValid && pass;
    strobe.usable    = usableNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      commit     <= 1'b0;
      fault      <= 1'b0;
      faultKind  <= EXC_NONE;
      intInhibit <= 1'b0;
    end else begin
      commit    <= loadValid && pass;
      fault     <= faultNow;
      faultKind <= faultNow ? verdict : EXC_NONE;
      // A fresh stack load sets; retire or a fault clears; no extension.
      if (ssCommitNow) begin
        intInhibit <= 1'b1;
      end else if (retire || faultNow) begin
        intInhibit <= 1'b0;
      end
    end
  end

  // R1: invalid target always yields an invalid-opcode fault.
  a_r1_invalid_target: assert property (@(posedge clk) disable iff (!rstN)
    loadValid && isInvalid |=> fault && (faultKind == EXC_UD));

  // R2: a null selector for a data register always commits.
  a_r2_null_data_commits: assert property (@(posedge clk) disable iff (!rstN)
    loadValid && isData && flags.isNull |=> commit && !fault);

  // R8: no request, no verdict.
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !loadValid |=> !commit && !fault);

  // R8: success and failure strobes are exclusive.
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({commit, fault}));

  // R9: a stack load leaves the shadow exactly when it commits.
  a_r9_shadow_follows_ss: assert property (@(posedge clk) disable iff (!rstN)
    loadValid && isSs |=> (intInhibit == commit));

  // R10: retire without a new request ends the shadow.
  a_r10_retire_clears: assert property (@(posedge clk) disable iff (!rstN)
    retire && !loadValid |=> !intInhibit);

endmodule

// File: rtl/segload_checker.sv
module segload_checker
  import segchk_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadValid,
  input  logic [2:0]        tgtSel,
  input  logic [SEL_W-1:0]  selector,
  input  logic [1:0]        cpl,
  input  logic              longMode,
  input  logic              descInLimit,
  input  logic              descPresent,
  input  logic [1:0]        descDpl,
  input  logic              descIsCode,
  input  logic              descWritable,
  input  logic              descReadable,
  input  logic              descConforming,
  input  logic              retire,
  output logic              commit,
  output logic              fault,
  output logic [2:0]        faultKind,
  output logic [SEL_W-1:0]  errCode,
  output logic              descUsable,
  output logic              intInhibit
);

  chkFlags_t   flags;
  ctrlStrobe_t strobe;

  segchk_datapath #(.SEL_W(SEL_W)) u_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .selector       (selector),
    .cpl            (cpl),
    .longMode       (longMode),
    .descInLimit    (descInLimit),
    .descPresent    (descPresent),
    .descDpl        (descDpl),
    .descIsCode     (descIsCode),
    .descWritable   (descWritable),
    .descReadable   (descReadable),
    .descConforming (descConforming),
    .strobe         (strobe),
    .flags          (flags),
    .errCode        (errCode),
    .descUsable     (descUsable)
  );

  segchk_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .loadValid  (loadValid),
    .tgtSel     (tgtSel),
    .retire     (retire),
    .flags      (flags),
    .strobe     (strobe),
    .commit     (commit),
    .fault      (fault),
    .faultKind  (faultKind),
    .intInhibit (intInhibit)
  );

endmodule

// File: tb/segload_checker_bench.sv
`timescale 1ns/1ps
module segload_checker_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadValid = 1'b0;
  logic [2:0]  tgtSel = '0;
  logic [15:0] selector = '0;
  logic [1:0]  cpl = '0;
  logic        longMode = 1'b0;
  logic        descInLimit = 1'b0;
  logic        descPresent = 1'b0;
  logic [1:0]  descDpl = '0;
  logic        descIsCode = 1'b0;
  logic        descWritable = 1'b0;
  logic        descReadable = 1'b0;
  logic        descConforming = 1'b0;
  logic        retire = 1'b0;
  logic        commit, fault, descUsable, intInhibit;
  logic [2:0]  faultKind;
  logic [15:0] errCode;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  segload_checker u_segload_checker (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .tgtSel(tgtSel),
    .selector(selector), .cpl(cpl), .longMode(longMode),
    .descInLimit(descInLimit), .descPresent(descPresent), .descDpl(descDpl),
    .descIsCode(descIsCode), .descWritable(descWritable),
    .descReadable(descReadable), .descConforming(descConforming),
    .retire(retire), .commit(commit), .fault(fault), .faultKind(faultKind),
    .errCode(errCode), .descUsable(descUsable), .intInhibit(intInhibit)
  );

  // Reference verdict built from the requirement text.
  function automatic void refModel(
    input int t, input logic [15:0] s, input int c, input bit lm,
    input bit il, input bit pr, input int d, input bit cd,
    input bit wr, input bit rd, input bit cf,
    output int kind, output logic [15:0] err, output bit usable,
    output string tag);
    int  rq;
    bit  nul;
    rq     = int'(s[1:0]);
    nul    = (s[15:2] == 14'd0);
    kind   = 0;
    err    = 16'd0;
    usable = 1'b0;
    if (t == 1 || t > 5) begin
      kind = 1; tag = "R1";
    end else if (t == 2) begin
      if (nul) begin
        tag = "R3";
        if (!(lm && c < 3 && rq == c)) kind = 2;
      end else if (!il || rq != c || d != c || cd || !wr) begin
        kind = 2; err = s & 16'hFFFC; tag = "R4";
      end else if (!pr) begin
        kind = 3; err = s & 16'hFFFC; tag = "R5";
      end else begin
        usable = 1'b1; tag = "R8";
      end
    end else begin
      if (nul) begin
        tag = "R2";
      end else if (!il || (cd && !rd) || ((!cd || !cf) && (rq > d || c > d))) begin
        kind = 2; err = s & 16'hFFFC; tag = "R6";
      end else if (!pr) begin
        kind = 4; err = s & 16'hFFFC; tag = "R7";
      end else begin
        usable = 1'b1; tag = "R8";
      end
    end
  endfunction

  task automatic checkOut(input string tag, input bit eCommit, input bit eFault,
                          input int eKind, input logic [15:0] eErr,
                          input bit eUsable, input bit eInh);
    checks++;
    if (commit !== eCommit || fault !== eFault || faultKind !== 3'(eKind) ||
        errCode !== eErr || descUsable !== eUsable || intInhibit !== eInh) begin
      errors++;
      $display("FAIL %s actual c=%0b f=%0b k=%0d e=%h u=%0b i=%0b expected c=%0b f=%0b k=%0d e=%h u=%0b i=%0b",
               tag, commit, fault, faultKind, errCode, descUsable, intInhibit,
               eCommit, eFault, eKind, eErr, eUsable, eInh);
    end
  endtask

  task automatic driveLoad(input int t, input logic [15:0] s, input int c,
                           input bit lm, input int attr, input int d);
    loadValid      = 1'b1;
    tgtSel         = 3'(t);
    selector       = s;
    cpl            = 2'(c);
    longMode       = lm;
    descDpl        = 2'(d);
    descInLimit    = attr[0];
    descPresent    = attr[1];
    descIsCode     = attr[2];
    descWritable   = attr[3];
    descReadable   = attr[4];
    descConforming = attr[5];
  endtask

  // A valid writable present data descriptor at privilege 0.
  task automatic goodSs();
    driveLoad(2, 16'h0040, 0, 1'b0, 6'b001011, 0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    checkOut("R8 reset", 0, 0, 0, 16'd0, 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R8 idle", 0, 0, 0, 16'd0, 0, 0);

    // R9: set on stack commit, held without retire, cleared by retire.
    goodSs();
    @(negedge clk);
    loadValid = 1'b0;
    checkOut("R9 set", 1, 0, 0, 16'd0, 1, 1);
    @(negedge clk);
    checkOut("R9 hold / R8 one-cycle strobe", 0, 0, 0, 16'd0, 0, 1);
    // R9: a data load while the shadow is active leaves it alone.
    driveLoad(3, 16'h0088, 0, 1'b0, 6'b000011, 0);
    @(negedge clk);
    loadValid = 1'b0;
    checkOut("R9 data load keeps shadow", 1, 0, 0, 16'd0, 1, 1);
    retire = 1'b1;
    @(negedge clk);
    retire = 1'b0;
    checkOut("R9 retire clears", 0, 0, 0, 16'd0, 0, 0);

    // R10: repeated stack load does not lengthen the shadow.
    goodSs();
    @(negedge clk);
    goodSs();
    @(negedge clk);
    loadValid = 1'b0;
    checkOut("R10 reload", 1, 0, 0, 16'd0, 1, 1);
    retire = 1'b1;
    @(negedge clk);
    retire = 1'b0;
    checkOut("R10 next retire clears", 0, 0, 0, 16'd0, 0, 0);

    // R9: a fault ends the shadow.
    goodSs();
    @(negedge clk);
    driveLoad(4, 16'h0104, 0, 1'b0, 6'b000001, 1);
    @(negedge clk);
    loadValid = 1'b0;
    checkOut("R9 fault clears (R7)", 0, 1, 4, 16'h0104, 0, 0);

    // Exhaustive sweep; retire held low, shadow tracked in the bench.
    begin
      bit          havePrev = 1'b0;
      bit          expInh = 1'b0;
      int          pKind;
      logic [15:0] pErr;
      bit          pUse;
      string       pTag;
      int          cnt = 0;
      for (int t = 0; t < 8; t++)
        for (int c = 0; c < 4; c++)
          for (int sv = 0; sv < 8; sv++)
            for (int d = 0; d < 4; d++)
              for (int lm = 0; lm < 2; lm++)
                for (int attr = 0; attr < 64; attr++) begin
                  logic [15:0] s;
                  int          k;
                  logic [15:0] e;
                  bit          u;
                  string       tg;
                  logic [13:0] idx;
                  idx = 14'((cnt * 37 + 5) & 14'h3FFF) | 14'd1;
                  s = sv[2] ? {idx, 2'(sv)} : {14'd0, 2'(sv)};
                  refModel(t, s, c, lm[0], attr[0], attr[1], d, attr[2],
                           attr[3], attr[4], attr[5], k, e, u, tg);
                  if (havePrev)
                    // R11: priority across every coexisting fault pair.
                    checkOut({pTag, "/R11"}, pKind == 0, pKind != 0, pKind, pErr,
                             pUse, expInh);
                  driveLoad(t, s, c, lm[0], attr, d);
                  @(negedge clk);
                  if (k != 0) expInh = 1'b0;
                  else if (t == 2) expInh = 1'b1;
                  pKind = k; pErr = e; pUse = u; pTag = tg;
                  havePrev = 1'b1;
                  cnt++;
                end
      checkOut({pTag, "/R11"}, pKind == 0, pKind != 0, pKind, pErr, pUse, expInh);
      loadValid = 1'b0;
      @(negedge clk);
      checkOut("R8 idle after sweep", 0, 0, 0, 16'd0, 0, expInh);
    end

    summary();
    $finish;
  end

endmodule